// File: doc/BRIEF.md
# GPIO Port Interrupt Detector

This block watches eight general-purpose input lines and turns chosen transitions or levels on them into interrupt requests. Each line first passes through a two-stage synchroniser and, if software asks for it, a debounce filter that accepts a new level only after it has held for a set number of clock cycles. Per line, software picks level or edge sensitivity, the active polarity, and whether the line may raise a request.

Edge events are held in a sticky latch until software acknowledges them by writing a one to that line's bit in an acknowledge register. Level requests track the filtered input and need no acknowledgement. The lines that hold an enabled, active request appear in a readable status register. They also drive eight per-line request outputs and one combined port request. Software that wants both edges reverses the polarity bit after each acknowledged edge. The detector compares each sample against the previous one, so a polarity change alone never creates an event.

Configuration uses a byte-wide register port. It has an address, a write strobe and write data. Read data is combinational from the address.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every readable register returns 0, `line_irq` is 0 and `port_irq` is 0.
- R2: A line in level mode (edge-select bit 0) with polarity bit 1 and enable bit 1 asserts its request while its filtered input is high, and releases it when the input goes low.
- R3: A line in level mode with polarity bit 0 and enable bit 1 asserts its request while its filtered input is low.
- R4: A line in edge mode (edge-select bit 1) with polarity bit 1 and enable bit 1 latches a request on a low-to-high input change. The request stays asserted after the input returns low.
- R5: A line in edge mode with polarity bit 0 and enable bit 1 latches a request on a high-to-low input change.
- R6: A write to the acknowledge register at 0x08 clears the latched edge request of every line whose data bit is 1. Lines written with 0 keep their latch. If a new event arrives in the same cycle, the event wins.
- R7: An acknowledge write has no effect on a line in level mode.
- R8: A line whose enable bit is 0 shows no request. An edge that occurs while the line is disabled is not latched, so it does not appear once the line is enabled again.
- R9: Changing a line's polarity without any input change does not create an edge event. This lets software emulate both-edge triggering by flipping polarity after each acknowledge.
- R10: With the line's debounce bit set, an input pulse shorter than DB_CYCLES clock cycles (default 4) is ignored, and a level held for at least that long is accepted. With the debounce bit clear, a 2-cycle pulse is detected.
- R11: `line_irq[i]` equals bit i of the status register. `port_irq` is 1 exactly when any status bit is 1.
- R12: Register map, one bit per line, bit i for line i: edge-select 0x00, polarity 0x04, acknowledge 0x08 (write-only, reads 0), enable 0x0C, debounce 0x10, status 0x14 (read-only), synchronised input level 0x18 (read-only). Writable registers read back the last value written. Writes to read-only addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Asynchronous GPIO input lines |
| reg_addr | input | 8 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| port_irq | output | 1 | OR of all status bits |
| line_irq | output | 8 | Per-line interrupt requests (status bits) |

## Verification
Each trigger mode is exercised with an input step and its return.

- **Level modes.** The request must follow the pin in both directions.
- **Edge modes.** The request must persist after the pin returns.
- **Acknowledge.** Acknowledge writes with mismatched and partial masks separate per-bit clearing from clearing the whole register. The same writes to a level-mode line show that they are ignored.
- **Disabled edge.** A pulse on a disabled line, followed by enabling that line, shows that the latch is gated and not merely the output.
- **Polarity flip.** Flipping polarity with the pin held steady checks that re-arming is clean.
- **Debounce.** Short and long pulses are sent with debounce on, and a short pulse with it off, to separate filtered lines from unfiltered ones.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] A_EDGE   = 8'h00;
  localparam logic [ADDR_W-1:0] A_POL    = 8'h04;
  localparam logic [ADDR_W-1:0] A_ACK    = 8'h08;
  localparam logic [ADDR_W-1:0] A_ENABLE = 8'h0C;
  localparam logic [ADDR_W-1:0] A_DEB    = 8'h10;
  localparam logic [ADDR_W-1:0] A_STATUS = 8'h14;
  localparam logic [ADDR_W-1:0] A_LEVEL  = 8'h18;
endpackage

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter #(
  parameter int NL        = 8,
  parameter int DB_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] pin_i,
  input  logic [NL-1:0] db_en_i,
  output logic [NL-1:0] lvl_o,
  output logic [NL-1:0] qual_o
);
  localparam int CW = (DB_CYCLES < 2) ? 1 : $clog2(DB_CYCLES);
  localparam logic [CW-1:0] CNT_LAST = CW'(DB_CYCLES - 1);

  logic [NL-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
    end
  end

  assign lvl_o = s2_q;

  for (genvar i = 0; i < NL; i++) begin : g_line
    logic [CW-1:0] cnt_q, cnt_d;
    logic          db_q, db_d;

    always_comb begin
      cnt_d = cnt_q;
      db_d  = db_q;
      if (!db_en_i[i]) begin
        db_d  = s2_q[i];
        cnt_d = '0;
      end else if (s2_q[i] == db_q) begin
        cnt_d = '0;
      end else if (cnt_q == CNT_LAST) begin
        db_d  = s2_q[i];
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        db_q  <= 1'b0;
      end else begin
        cnt_q <= cnt_d;
        db_q  <= db_d;
      end
    end

    assign qual_o[i] = db_en_i[i] ? db_q : s2_q[i];
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NL = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] qual_i,
  input  logic [NL-1:0] edge_i,
  input  logic [NL-1:0] pol_i,
  input  logic [NL-1:0] en_i,
  input  logic [NL-1:0] ack_i,
  output logic [NL-1:0] ev_o,
  output logic [NL-1:0] lat_o,
  output logic [NL-1:0] status_o
);
  logic [NL-1:0] prev_q;
  logic [NL-1:0] lat_q, lat_d;
  logic [NL-1:0] rise, fall;

  always_comb begin
    rise     = qual_i & ~prev_q;
    fall     = ~qual_i & prev_q;
    ev_o     = en_i & edge_i & ((pol_i & rise) | (~pol_i & fall));
    lat_d    = (lat_q & ~ack_i) | ev_o;
    status_o = en_i & ((edge_i & lat_q) | (~edge_i & ~(qual_i ^ pol_i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      lat_q  <= '0;
    end else begin
      prev_q <= qual_i;
      lat_q  <= lat_d;
    end
  end

  assign lat_o = lat_q;
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NL = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [NL-1:0]     wdata_i,
  input  logic [NL-1:0]     status_i,
  input  logic [NL-1:0]     lvl_i,
  output logic [NL-1:0]     edge_o,
  output logic [NL-1:0]     pol_o,
  output logic [NL-1:0]     en_o,
  output logic [NL-1:0]     db_o,
  output logic [NL-1:0]     ack_o,
  output logic [NL-1:0]     rdata_o
);
  logic [NL-1:0] edge_q, pol_q, en_q, db_q;
  logic [NL-1:0] edge_d, pol_d, en_d, db_d;
  logic          wr_edge, wr_pol, wr_en, wr_db;

  always_comb begin
    wr_edge = we_i && (addr_i == A_EDGE);
    wr_pol  = we_i && (addr_i == A_POL);
    wr_en   = we_i && (addr_i == A_ENABLE);
    wr_db   = we_i && (addr_i == A_DEB);
    edge_d  = wr_edge ? wdata_i : edge_q;
    pol_d   = wr_pol  ? wdata_i : pol_q;
    en_d    = wr_en   ? wdata_i : en_q;
    db_d    = wr_db   ? wdata_i : db_q;
    ack_o   = (we_i && (addr_i == A_ACK)) ? wdata_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
      db_q   <= '0;
    end else begin
      edge_q <= edge_d;
      pol_q  <= pol_d;
      en_q   <= en_d;
      db_q   <= db_d;
    end
  end

  always_comb begin
    case (addr_i)
      A_EDGE:   rdata_o = edge_q;
      A_POL:    rdata_o = pol_q;
      A_ENABLE: rdata_o = en_q;
      A_DEB:    rdata_o = db_q;
      A_STATUS: rdata_o = status_i;
      A_LEVEL:  rdata_o = lvl_i;
      default:  rdata_o = '0;
    endcase
  end

  assign edge_o = edge_q;
  assign pol_o  = pol_q;
  assign en_o   = en_q;
  assign db_o   = db_q;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NL        = 8,
  parameter int DB_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NL-1:0]     pin_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [NL-1:0]     reg_wdata,
  output logic [NL-1:0]     reg_rdata,
  output logic              port_irq,
  output logic [NL-1:0]     line_irq
);
  logic [NL-1:0] edge_q, pol_q, en_q, db_q, ack_w;
  logic [NL-1:0] lvl_w, qual_w, ev_w, lat_w, status_w;

  gpio_irq_regs #(.NL(NL)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (reg_addr),
    .we_i     (reg_we),
    .wdata_i  (reg_wdata),
    .status_i (status_w),
    .lvl_i    (lvl_w),
    .edge_o   (edge_q),
    .pol_o    (pol_q),
    .en_o     (en_q),
    .db_o     (db_q),
    .ack_o    (ack_w),
    .rdata_o  (reg_rdata)
  );

  gpio_irq_filter #(.NL(NL), .DB_CYCLES(DB_CYCLES)) u_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   (pin_i),
    .db_en_i (db_q),
    .lvl_o   (lvl_w),
    .qual_o  (qual_w)
  );

  gpio_irq_detect #(.NL(NL)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .qual_i   (qual_w),
    .edge_i   (edge_q),
    .pol_i    (pol_q),
    .en_i     (en_q),
    .ack_i    (ack_w),
    .ev_o     (ev_w),
    .lat_o    (lat_w),
    .status_o (status_w)
  );

  assign line_irq = status_w;
  assign port_irq = |status_w;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_irq_pkg::*;
#(
  parameter int NL = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [NL-1:0]     reg_wdata,
  input logic [NL-1:0]     line_irq,
  input logic [NL-1:0]     edge_q,
  input logic [NL-1:0]     en_q,
  input logic [NL-1:0]     qual_w,
  input logic [NL-1:0]     ev_w,
  input logic [NL-1:0]     lat_w
);
  for (genvar i = 0; i < NL; i++) begin : g_chk
    // R4: an edge request persists while nothing is written
    a_r4_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (line_irq[i] && edge_q[i] && en_q[i] && !reg_we) |=> line_irq[i]);

    // R6: acknowledged bit clears when no new event collides
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_q[i] && reg_we && reg_addr == A_ACK && reg_wdata[i] && !ev_w[i])
      |=> !lat_w[i]);

    // R7: acknowledge leaves level-mode requests alone
    a_r7_level_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_q[i] && reg_we && reg_addr == A_ACK)
      |=> ((qual_w[i] != $past(qual_w[i])) || (line_irq[i] == $past(line_irq[i]))));

    // R9: a latch only rises after a real change of the filtered input
    a_r9_latch_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lat_w[i]) |-> ($past(qual_w[i]) != $past(qual_w[i], 2)));
  end
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NL(NL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .line_irq  (line_irq),
  .edge_q    (edge_q),
  .en_q      (en_q),
  .qual_w    (qual_w),
  .ev_w      (ev_w),
  .lat_w     (lat_w)
);

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin = '0;
  logic [7:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       port_irq;
  logic [7:0] line_irq;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  gpio_irq_port uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .reg_addr(addr), .reg_we(we),
    .reg_wdata(wdata), .reg_rdata(rdata), .port_irq(port_irq), .line_irq(line_irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; addr = 8'h00; wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic clear_all();
    wr(8'h0C, 8'h00);
    wr(8'h00, 8'h00);
    wr(8'h04, 8'h00);
    wr(8'h10, 8'h00);
    wr(8'h08, 8'hFF);
  endtask

  task automatic t_reset();
    chk("R1 line_irq", line_irq, 8'h00);
    chk("R1 port_irq", {7'd0, port_irq}, 8'h00);
    rd_chk("R1 edge", 8'h00, 8'h00);
    rd_chk("R1 pol", 8'h04, 8'h00);
    rd_chk("R1 enable", 8'h0C, 8'h00);
    rd_chk("R1 debounce", 8'h10, 8'h00);
    rd_chk("R1 status", 8'h14, 8'h00);
  endtask

  task automatic t_regs();
    wr(8'h00, 8'hA5);
    wr(8'h04, 8'h3C);
    wr(8'h10, 8'h81);
    wr(8'h14, 8'hFF);
    rd_chk("R12 edge readback", 8'h00, 8'hA5);
    rd_chk("R12 pol readback", 8'h04, 8'h3C);
    rd_chk("R12 debounce readback", 8'h10, 8'h81);
    rd_chk("R12 ack reads zero", 8'h08, 8'h00);
    rd_chk("R12 status write ignored", 8'h14, 8'h00);
    wr(8'h10, 8'h00);
    pin = 8'h5A;
    tick(4);
    rd_chk("R12 input level", 8'h18, 8'h5A);
    pin = 8'h00;
    tick(4);
    clear_all();
  endtask

  task automatic t_level_high();
    wr(8'h04, 8'h01);
    wr(8'h0C, 8'h01);
    tick(3);
    chk("R2 low input idle", line_irq, 8'h00);
    pin[0] = 1'b1;
    tick(4);
    chk("R2 high asserts", line_irq, 8'h01);
    chk("R11 port_irq", {7'd0, port_irq}, 8'h01);
    rd_chk("R11 status", 8'h14, 8'h01);
    pin[0] = 1'b0;
    tick(4);
    chk("R2 release", line_irq, 8'h00);
    chk("R11 port_irq low", {7'd0, port_irq}, 8'h00);
    clear_all();
  endtask

  task automatic t_level_low();
    pin[1] = 1'b1;
    tick(4);
    wr(8'h0C, 8'h02);
    tick(2);
    chk("R3 high input idle", line_irq, 8'h00);
    pin[1] = 1'b0;
    tick(4);
    chk("R3 low asserts", line_irq, 8'h02);
    wr(8'h08, 8'h02);
    tick(1);
    chk("R7 ack ignored in level mode", line_irq, 8'h02);
    pin[1] = 1'b1;
    tick(4);
    chk("R3 release", line_irq, 8'h00);
    clear_all();
    pin[1] = 1'b0;
    tick(4);
  endtask

  task automatic t_rise();
    wr(8'h00, 8'h04);
    wr(8'h04, 8'h04);
    wr(8'h0C, 8'h04);
    pin[2] = 1'b1;
    tick(5);
    chk("R4 rising latched", line_irq, 8'h04);
    pin[2] = 1'b0;
    tick(5);
    chk("R4 held after return", line_irq, 8'h04);
    wr(8'h08, 8'h02);
    tick(1);
    chk("R6 other bit ack keeps latch", line_irq, 8'h04);
    wr(8'h08, 8'h04);
    tick(1);
    chk("R6 ack clears", line_irq, 8'h00);
    clear_all();
  endtask

  task automatic t_fall();
    pin[3] = 1'b1;
    tick(4);
    wr(8'h00, 8'h08);
    wr(8'h0C, 8'h08);
    tick(3);
    chk("R5 no event while high", line_irq, 8'h00);
    pin[3] = 1'b0;
    tick(5);
    chk("R5 falling latched", line_irq, 8'h08);
    wr(8'h08, 8'h08);
    tick(1);
    chk("R5 ack clears", line_irq, 8'h00);
    clear_all();
  endtask

  task automatic t_partial_ack();
    wr(8'h00, 8'h30);
    wr(8'h04, 8'h30);
    wr(8'h0C, 8'h30);
    pin[5:4] = 2'b11;
    tick(5);
    chk("R6 both latched", line_irq, 8'h30);
    wr(8'h08, 8'h10);
    tick(1);
    chk("R6 partial ack", line_irq, 8'h20);
    rd_chk("R11 status after partial ack", 8'h14, 8'h20);
    clear_all();
    pin[5:4] = 2'b00;
    tick(4);
  endtask

  task automatic t_enable();
    wr(8'h00, 8'h40);
    wr(8'h04, 8'h40);
    pin[6] = 1'b1;
    tick(5);
    chk("R8 disabled no request", line_irq, 8'h00);
    rd_chk("R8 disabled status", 8'h14, 8'h00);
    wr(8'h0C, 8'h40);
    tick(2);
    chk("R8 no stale latch on enable", line_irq, 8'h00);
    clear_all();
    pin[6] = 1'b0;
    tick(4);
  endtask

  task automatic t_polarity();
    wr(8'h00, 8'h80);
    wr(8'h04, 8'h80);
    wr(8'h0C, 8'h80);
    pin[7] = 1'b1;
    tick(5);
    chk("R9 first rising", line_irq, 8'h80);
    wr(8'h08, 8'h80);
    wr(8'h0C, 8'h00);
    wr(8'h04, 8'h00);
    wr(8'h0C, 8'h80);
    tick(4);
    chk("R9 flip creates no event", line_irq, 8'h00);
    pin[7] = 1'b0;
    tick(5);
    chk("R9 falling after flip", line_irq, 8'h80);
    clear_all();
  endtask

  task automatic t_debounce();
    wr(8'h00, 8'h01);
    wr(8'h04, 8'h01);
    wr(8'h10, 8'h01);
    wr(8'h0C, 8'h01);
    pin[0] = 1'b1;
    tick(2);
    pin[0] = 1'b0;
    tick(10);
    chk("R10 short pulse filtered", line_irq, 8'h00);
    pin[0] = 1'b1;
    tick(10);
    pin[0] = 1'b0;
    tick(10);
    chk("R10 long pulse accepted", line_irq, 8'h01);
    wr(8'h08, 8'h01);
    wr(8'h10, 8'h00);
    tick(2);
    pin[0] = 1'b1;
    tick(2);
    pin[0] = 1'b0;
    tick(6);
    chk("R10 short pulse without filter", line_irq, 8'h01);
    clear_all();
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_regs();
    t_level_high();
    t_level_low();
    t_rise();
    t_fall();
    t_partial_ack();
    t_enable();
    t_polarity();
    t_debounce();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule